// File: doc/BRIEF.md
# Framed 24-bit Word I2C Target

This block is the peripheral side of a two-wire serial link that moves 24-bit words rather than single bytes. After a START the bus master sends a 7-bit address with a direction bit. A write transfer carries a three-byte command word and then a number of three-byte data words. The command word itself says how many data words follow. A read transfer is linked to a command sent just before it. The master sends the command with a write address, issues a repeated START with no STOP in between, addresses the target for reading, and then clocks out the number of words that the command asked for.

Toward internal logic the block gives three things. A one-cycle strobe marks each complete command word. A one-cycle strobe carries each received data word together with its position in the transfer. A request/response pair fetches each word to be returned on a read. The data line is open-drain: the block only ever pulls it low, through an output enable. SCL and SDA are brought into the system clock domain through a synchroniser. The block then finds edges and START/STOP conditions by oversampling, so the system clock must run many times faster than SCL.

Top module: `i2c_cmd_target`

## Requirements
- R1: After reset, sda_oe, cmd_valid, wr_valid and rd_req are all low, and the block waits for a START.
- R2: The block acknowledges (pulls SDA low in the ninth clock) the address byte 0x30, which means write. Any other byte in the address slot is not acknowledged, and the block then stays off the bus, with no strobes, until the next START or STOP.
- R3: After a write address, the block acknowledges three command bytes, most significant first. It then pulses cmd_valid for one cycle with cmd_word equal to the three bytes joined.
- R4: The word count of a transfer is cmd_word[2:0] + 1 (parameter field), so it runs from 1 to 8.
- R5: Each data byte after the command is acknowledged. Every three bytes, high byte first, form a word. Each word is given out with a one-cycle wr_valid pulse and with wr_index counting 0, 1, ... in order.
- R6: Once the counted number of data words has been taken, further bytes are not acknowledged and produce no wr_valid.
- R7: After a command and a repeated START, address byte 0x31 is acknowledged. The block raises rd_req for one cycle with rd_index 0, 1, ... for each word, captures rd_data in that cycle, and shifts each word out high byte first, MSB first.
- R8: Address 0x31 is not acknowledged unless a command word has completed earlier in the same transfer (since the last STOP).
- R9: A NACK from the master on a read byte makes the block release SDA. It does not drive SDA again until a new START.
- R10: If the master acknowledges the last byte of the last counted word, the block releases SDA, so further read clocks return 0xFF, and it issues no further rd_req.
- R11: A START or STOP seen at any point, including in the middle of a byte, discards the partial byte. After a START the block is back at the address slot; after a STOP it is idle.
- R12: A transfer that stops right after the three command bytes gives one cmd_valid and no wr_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe | output | 1 | High pulls SDA low |
| cmd_valid | output | 1 | One-cycle strobe: command word complete |
| cmd_word | output | 24 | Last received command word |
| wr_valid | output | 1 | One-cycle strobe: write word complete |
| wr_data | output | 24 | Received write word |
| wr_index | output | 3 | Position of the write word in the transfer |
| rd_req | output | 1 | One-cycle request for a read word |
| rd_index | output | 3 | Position of the requested read word |
| rd_data | input | 24 | Read word, valid while rd_req is high |

## Verification
A wrong phase or counter inside the block shows up at the pins within one byte time. It appears as an acknowledge bit with the wrong level, a strobe carrying the wrong word or index, an rd_req that comes too early or too late, or SDA held low when the bench master expects the line released. The bench keeps its own queues of the words, indices and requests that the requirements predict for each transfer. It checks every strobe against them on the clock where the strobe appears. In the stretches after a NACK or past the word count, it also checks on every clock that the block is not driving SDA. Mid-byte START and over-count bytes are exercised because a counter that fails to reset or saturate there would corrupt the next transfer rather than the current one.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_CMD   = 3'd2,
    PH_WDATA = 3'd3,
    PH_RDATA = 3'd4,
    PH_RACK  = 3'd5,
    PH_HOLD  = 3'd6
  } phase_t;

  // 8-bit address slot value for a 7-bit address and a direction bit (1 = read)
  function automatic logic [7:0] slot_byte(input logic [6:0] a7, input logic rd);
    return {a7, rd};
  endfunction

endpackage

// File: rtl/i2c_cmd_cond.sv
module i2c_cmd_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s    = scl_ff[SYNC_STAGES-1];
  assign sda_s    = sda_ff[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0] ADDR7      = 7'h18,
  parameter int         WORD_BYTES = 3,
  parameter int         CNT_LSB    = 0,
  parameter int         CNT_BITS   = 3,
  localparam int        WORD_W     = 8 * WORD_BYTES,
  localparam int        BI_W       = $clog2(WORD_BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_s,
  input  logic                sda_s,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_ev,
  input  logic                stop_ev,
  output logic                sda_oe,
  output logic                cmd_valid,
  output logic [WORD_W-1:0]   cmd_word,
  output logic                wr_valid,
  output logic [WORD_W-1:0]   wr_data,
  output logic [CNT_BITS-1:0] wr_index,
  output logic                rd_req,
  output logic [CNT_BITS-1:0] rd_index,
  input  logic [WORD_W-1:0]   rd_data
);

  localparam logic [BI_W-1:0] LAST_B = BI_W'(WORD_BYTES - 1);

  // word count carried by a command word
  function automatic logic [CNT_BITS:0] words_in(input logic [WORD_W-1:0] c);
    return {1'b0, c[CNT_LSB +: CNT_BITS]} + 1'b1;
  endfunction

  phase_t              ph, after_ack;
  logic                in_ack, cmd_ok, mack;
  logic [3:0]          bitcnt;
  logic [7:0]          sh;
  logic [WORD_W-1:0]   acc, rsh;
  logic [BI_W-1:0]     bidx;
  logic [CNT_BITS:0]   widx, wcnt;

  // named internal events
  logic rx_phase, byte_done, word_done, wr_hit, rd_hit;
  logic [WORD_W-1:0] asm_word;
  logic [CNT_BITS:0] widx_nx;

  assign rx_phase  = (ph == PH_ADDR) || (ph == PH_CMD) || (ph == PH_WDATA);
  assign byte_done = rx_phase && !in_ack && scl_fall && (bitcnt == 4'd8);
  assign word_done = byte_done && (bidx == LAST_B);
  assign asm_word  = {acc[WORD_W-9:0], sh};
  assign wr_hit    = (sh == slot_byte(ADDR7, 1'b0));
  assign rd_hit    = (sh == slot_byte(ADDR7, 1'b1)) && cmd_ok;
  assign widx_nx   = widx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE;  after_ack <= PH_IDLE;
      in_ack <= 1'b0; cmd_ok <= 1'b0; mack <= 1'b1;
      bitcnt <= '0;   sh <= '0; acc <= '0; rsh <= '0;
      bidx <= '0;     widx <= '0; wcnt <= '0;
      sda_oe <= 1'b0; cmd_valid <= 1'b0; cmd_word <= '0;
      wr_valid <= 1'b0; wr_data <= '0; wr_index <= '0;
      rd_req <= 1'b0; rd_index <= '0;
    end else begin
      cmd_valid <= 1'b0;
      wr_valid  <= 1'b0;
      rd_req    <= 1'b0;
      if (rd_req) rsh <= rd_data;
      if (start_ev) begin
        ph <= PH_ADDR; in_ack <= 1'b0; bitcnt <= '0; sda_oe <= 1'b0; bidx <= '0;
      end else if (stop_ev) begin
        ph <= PH_IDLE; in_ack <= 1'b0; bitcnt <= '0; sda_oe <= 1'b0; cmd_ok <= 1'b0;
      end else begin
        case (ph)
          PH_ADDR, PH_CMD, PH_WDATA: begin
            if (in_ack) begin
              if (scl_fall) begin
                in_ack <= 1'b0;
                ph     <= after_ack;
                if (after_ack == PH_RDATA) begin
                  sda_oe <= ~rsh[WORD_W-1];
                  rsh    <= rsh << 1;
                  bitcnt <= 4'd1;
                end else begin
                  sda_oe <= 1'b0;
                  bitcnt <= '0;
                end
              end
            end else begin
              if (scl_rise && bitcnt != 4'd8) begin
                sh     <= {sh[6:0], sda_s};
                bitcnt <= bitcnt + 4'd1;
              end
              if (byte_done) begin
                case (ph)
                  PH_ADDR: begin
                    if (wr_hit) begin
                      sda_oe <= 1'b1; in_ack <= 1'b1; after_ack <= PH_CMD;
                      bidx <= '0; cmd_ok <= 1'b0;
                    end else if (rd_hit) begin
                      sda_oe <= 1'b1; in_ack <= 1'b1; after_ack <= PH_RDATA;
                      bidx <= '0; widx <= '0; rd_req <= 1'b1; rd_index <= '0;
                    end else begin
                      ph <= PH_HOLD; cmd_ok <= 1'b0;
                    end
                  end
                  PH_CMD: begin
                    sda_oe <= 1'b1; in_ack <= 1'b1; acc <= asm_word;
                    if (word_done) begin
                      cmd_valid <= 1'b1; cmd_word <= asm_word;
                      wcnt <= words_in(asm_word); widx <= '0; bidx <= '0;
                      cmd_ok <= 1'b1; after_ack <= PH_WDATA;
                    end else begin
                      bidx <= bidx + 1'b1; after_ack <= PH_CMD;
                    end
                  end
                  default: begin
                    if (widx >= wcnt) begin
                      ph <= PH_HOLD;
                    end else begin
                      sda_oe <= 1'b1; in_ack <= 1'b1; acc <= asm_word;
                      after_ack <= PH_WDATA;
                      if (word_done) begin
                        wr_valid <= 1'b1; wr_data <= asm_word;
                        wr_index <= widx[CNT_BITS-1:0];
                        widx <= widx_nx; bidx <= '0;
                      end else begin
                        bidx <= bidx + 1'b1;
                      end
                    end
                  end
                endcase
              end
            end
          end
          PH_RDATA: begin
            if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0; ph <= PH_RACK;
              end else begin
                sda_oe <= ~rsh[WORD_W-1]; rsh <= rsh << 1; bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          PH_RACK: begin
            if (scl_rise) begin
              mack <= sda_s;
              if (!sda_s && bidx == LAST_B && widx_nx < wcnt) begin
                rd_req <= 1'b1; rd_index <= widx_nx[CNT_BITS-1:0];
              end
            end
            if (scl_fall) begin
              if (mack) begin
                ph <= PH_HOLD;
              end else if (bidx == LAST_B && widx_nx >= wcnt) begin
                widx <= widx_nx; ph <= PH_HOLD;
              end else begin
                if (bidx == LAST_B) begin
                  bidx <= '0; widx <= widx_nx;
                end else begin
                  bidx <= bidx + 1'b1;
                end
                sda_oe <= ~rsh[WORD_W-1]; rsh <= rsh << 1;
                bitcnt <= 4'd1; ph <= PH_RDATA;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11: a START always lands in the address slot with SDA released
  a_r11_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (ph == PH_ADDR && !sda_oe));
  // R11: a STOP always returns to idle with SDA released
  a_r11_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (ph == PH_IDLE && !sda_oe));
  // R9 / R10: the held state never drives the line
  a_r9_hold_released: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_HOLD || ph == PH_IDLE) |-> !sda_oe);
  // R2: the target only starts pulling SDA low while SCL is low
  a_r2_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  // R3: command strobe lasts one cycle
  a_r3_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  // R6: no write word index reaches the counted limit
  a_r6_wr_in_count: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ({1'b0, wr_index} < wcnt));
  // R10: no read request beyond the counted words
  a_r10_rd_in_count: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ({1'b0, rd_index} < wcnt));

endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target #(
  parameter logic [6:0] ADDR7       = 7'h18,
  parameter int         WORD_BYTES  = 3,
  parameter int         CNT_LSB     = 0,
  parameter int         CNT_BITS    = 3,
  parameter int         SYNC_STAGES = 2,
  localparam int        WORD_W      = 8 * WORD_BYTES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe,
  output logic                cmd_valid,
  output logic [WORD_W-1:0]   cmd_word,
  output logic                wr_valid,
  output logic [WORD_W-1:0]   wr_data,
  output logic [CNT_BITS-1:0] wr_index,
  output logic                rd_req,
  output logic [CNT_BITS-1:0] rd_index,
  input  logic [WORD_W-1:0]   rd_data
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  i2c_cmd_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_cmd_engine #(
    .ADDR7(ADDR7), .WORD_BYTES(WORD_BYTES), .CNT_LSB(CNT_LSB), .CNT_BITS(CNT_BITS)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .sda_oe(sda_oe), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_index(wr_index),
    .rd_req(rd_req), .rd_index(rd_index), .rd_data(rd_data)
  );

endmodule

// File: tb/i2c_cmd_target_tb.sv
module i2c_cmd_target_tb;

  localparam int H = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, cmd_valid, wr_valid, rd_req;
  logic [23:0] cmd_word, wr_data, rd_data;
  logic [2:0]  wr_index, rd_index;
  wire  sda_line = sda_m & ~sda_oe;

  i2c_cmd_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_index(wr_index), .rd_req(rd_req),
    .rd_index(rd_index), .rd_data(rd_data)
  );

  function automatic logic [23:0] pat(input int i);
    return 24'(32'h8C4A21 + i * 32'h112233);
  endfunction
  assign rd_data = pat(int'(rd_index));

  int n_chk = 0, n_bad = 0;
  bit quiet = 1'b0, done = 1'b0;
  logic [23:0] q_cmd[$], q_wr[$];
  int q_wi[$], q_ri[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference comparison on every clock
  always @(negedge clk) if (rst_n && !done) begin
    if (cmd_valid) begin
      if (q_cmd.size() == 0) check(0, "R3 unexpected cmd_valid", cmd_word, 0);
      else begin logic [23:0] e; e = q_cmd.pop_front(); check(cmd_word == e, "R3 cmd_word", cmd_word, e); end
    end
    if (wr_valid) begin
      if (q_wr.size() == 0) check(0, "R6 unexpected wr_valid", wr_data, 0);
      else begin
        logic [23:0] e; int ei;
        e = q_wr.pop_front(); ei = q_wi.pop_front();
        check(wr_data == e, "R5 wr_data", wr_data, e);
        check(int'(wr_index) == ei, "R5 wr_index", wr_index, ei);
      end
    end
    if (rd_req) begin
      if (q_ri.size() == 0) check(0, "R10 unexpected rd_req", rd_index, 0);
      else begin int ei; ei = q_ri.pop_front(); check(int'(rd_index) == ei, "R7 rd_index", rd_index, ei); end
    end
    if (quiet) check(!sda_oe, "R9 SDA driven while released", sda_oe, 0);
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; scl_m = 1; tick(H); sda_m = 0; tick(H); scl_m = 0; tick(4);
  endtask
  task automatic bus_rstart();
    sda_m = 1; tick(H); scl_m = 1; tick(H); sda_m = 0; tick(H); scl_m = 0; tick(4);
  endtask
  task automatic bus_stop();
    sda_m = 0; tick(H); scl_m = 1; tick(H); sda_m = 1; tick(H);
  endtask
  task automatic send_bits(input int n, input logic [7:0] b);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(H); scl_m = 1; tick(H); scl_m = 0; tick(4);
    end
  endtask
  task automatic wbyte(input logic [7:0] b, output logic ack);
    send_bits(8, b);
    sda_m = 1; tick(H - 4); scl_m = 1; tick(H / 2); ack = sda_line;
    tick(H / 2); scl_m = 0; tick(4);
  endtask
  task automatic rbyte(input logic mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl_m = 1; tick(H / 2); b[i] = sda_line; tick(H / 2); scl_m = 0; tick(4);
    end
    sda_m = mack; tick(H); scl_m = 1; tick(H); scl_m = 0; tick(4); sda_m = 1;
  endtask

  task automatic wexp(input logic [7:0] b, input logic exp_ack, input string req);
    logic a;
    wbyte(b, a);
    check(a == exp_ack, req, a, exp_ack);
  endtask
  task automatic wword(input logic [23:0] w, input logic exp_ack, input string req);
    wexp(w[23:16], exp_ack, req); wexp(w[15:8], exp_ack, req); wexp(w[7:0], exp_ack, req);
  endtask
  task automatic rexp(input logic mack, input logic [7:0] e, input string req);
    logic [7:0] b;
    rbyte(mack, b);
    check(b == e, req, b, e);
  endtask
  task automatic queues_empty(input string req);
    check(q_cmd.size() + q_wr.size() + q_ri.size() == 0, req,
          q_cmd.size() + q_wr.size() + q_ri.size(), 0);
  endtask

  initial begin
    logic [23:0] p;
    tick(5);
    check(!sda_oe && !cmd_valid && !wr_valid && !rd_req, "R1 reset outputs",
          {sda_oe, cmd_valid, wr_valid, rd_req}, 0);
    rst_n = 1; tick(10);
    check(!sda_oe, "R1 idle after reset", sda_oe, 0);

    // R3 R4 R5 R6: command with count field 2 -> 3 words, then one extra byte
    q_cmd.push_back(24'h123402);
    q_wr.push_back(24'hA1B2C3); q_wi.push_back(0);
    q_wr.push_back(24'h445566); q_wi.push_back(1);
    q_wr.push_back(24'h0F0E0D); q_wi.push_back(2);
    bus_start();
    wexp(8'h30, 1'b0, "R2 write address ack");
    wword(24'h123402, 1'b0, "R3 command byte ack");
    wword(24'hA1B2C3, 1'b0, "R5 data byte ack");
    wword(24'h445566, 1'b0, "R5 data byte ack");
    wword(24'h0F0E0D, 1'b0, "R4 last counted word ack");
    wexp(8'h99, 1'b1, "R6 byte beyond count not acked");
    bus_stop();
    queues_empty("R6 write transfer events");

    // R12: command only
    q_cmd.push_back(24'hABCDE5);
    bus_start();
    wexp(8'h30, 1'b0, "R2 write address ack");
    wword(24'hABCDE5, 1'b0, "R12 command byte ack");
    bus_stop();
    queues_empty("R12 command-only events");

    // R7: read two words after command
    q_cmd.push_back(24'h000401);
    q_ri.push_back(0); q_ri.push_back(1);
    bus_start();
    wexp(8'h30, 1'b0, "R2 write address ack");
    wword(24'h000401, 1'b0, "R3 command byte ack");
    bus_rstart();
    wexp(8'h31, 1'b0, "R7 read address ack");
    for (int w = 0; w < 2; w++) begin
      p = pat(w);
      rexp(1'b0, p[23:16], "R7 read high byte");
      rexp(1'b0, p[15:8], "R7 read mid byte");
      rexp(w == 1, p[7:0], "R7 read low byte");
    end
    bus_stop();
    queues_empty("R7 read events");

    // R10: master acks past the single counted word
    q_cmd.push_back(24'h777770);
    q_ri.push_back(0);
    bus_start();
    wexp(8'h30, 1'b0, "R2 write address ack");
    wword(24'h777770, 1'b0, "R3 command byte ack");
    bus_rstart();
    wexp(8'h31, 1'b0, "R7 read address ack");
    p = pat(0);
    rexp(1'b0, p[23:16], "R10 read high byte");
    rexp(1'b0, p[15:8], "R10 read mid byte");
    rexp(1'b0, p[7:0], "R10 read low byte");
    tick(6); quiet = 1;
    rexp(1'b1, 8'hFF, "R10 released past count");
    bus_stop(); quiet = 0;
    queues_empty("R10 read events");

    // R9: master NACK ends the read early
    q_cmd.push_back(24'h000003);
    q_ri.push_back(0);
    bus_start();
    wexp(8'h30, 1'b0, "R2 write address ack");
    wword(24'h000003, 1'b0, "R3 command byte ack");
    bus_rstart();
    wexp(8'h31, 1'b0, "R7 read address ack");
    p = pat(0);
    rexp(1'b0, p[23:16], "R9 read high byte");
    rexp(1'b1, p[15:8], "R9 read mid byte");
    tick(6); quiet = 1;
    rexp(1'b1, 8'hFF, "R9 released after NACK");
    bus_stop(); quiet = 0;
    queues_empty("R9 read events");

    // R8: read address with no command in this transfer
    bus_start();
    wexp(8'h31, 1'b1, "R8 read address without command");
    bus_stop();

    // R2: foreign address, following bytes ignored
    bus_start();
    wexp(8'h52, 1'b1, "R2 foreign address not acked");
    tick(6); quiet = 1;
    wexp(8'h12, 1'b1, "R2 byte after foreign address ignored");
    bus_stop(); quiet = 0;
    queues_empty("R2 no strobes after foreign address");

    // R11: START in the middle of a byte restarts the address slot
    q_cmd.push_back(24'h000000);
    q_wr.push_back(24'hDEAD01); q_wi.push_back(0);
    bus_start();
    wexp(8'h30, 1'b0, "R2 write address ack");
    send_bits(4, 8'hA5);
    bus_rstart();
    wexp(8'h30, 1'b0, "R11 address after mid-byte START");
    wword(24'h000000, 1'b0, "R11 command byte ack");
    wword(24'hDEAD01, 1'b0, "R11 data byte ack");
    bus_stop();
    queues_empty("R11 events after mid-byte START");

    tick(20);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule